// File: doc/BRIEF.md
# Divided Countdown Timer

This block is a per-processor countdown timer. A prescaler divides an incoming bus tick strobe by a power of two chosen through a divide-configuration register. A current-count register counts down once per divided tick from a programmed initial count. A timer entry register selects an interrupt vector, a mask and either one-shot or periodic operation. All configuration arrives over a single-cycle register write port. Writing the initial count cancels whatever count is in progress and starts again from the new value.

Every expiry increments a saturating pending counter. An interrupt request carrying the entry's vector is raised while expiries are pending, hardware enable is high and the entry is unmasked. Each acknowledge taken while the request is high retires one pending expiry. A software-enable bit in a control register governs masking. Clearing it masks the entry and discards all pending expiries.

Top module: `div_countdown_timer`

## Requirements
- R1: After reset the entry reads 0x0001_0000 (masked, vector 0, one-shot), the initial count and divide configuration read 0, the current count and pending count are 0, software enable is 0 and no request is raised.
- R2: The divide ratio is 2 to the power ((({cfg[3],cfg[1],cfg[0]} + 1) mod 8)). Configuration 0xB divides by 1, 0x0 by 2, 0x3 by 16, and bit 2 has no effect.
- R3: A write to select 1 (initial count) sets the current count to the written value on the next cycle and restarts the prescaler, even while a count is running.
- R4: The current count falls by one after each group of ratio bus ticks. In one-shot mode (entry bit 17 = 0) it stops at zero after a single expiry.
- R5: In periodic mode (entry bit 17 = 1), on the divided tick that would take the count to zero, the count reloads the initial count and an expiry is recorded. One expiry therefore occurs every initial-count × ratio bus ticks.
- R6: An initial count of zero stops the timer. The current count then reads 0 and no expiry occurs however many bus ticks arrive.
- R7: A write to select 0 (entry) keeps the vector in bits 7:0, the mask in bit 16 and periodic mode in bit 17. Every other bit of the entry reads 0.
- R8: While software enable is 0, an entry write always leaves the mask bit set.
- R9: A write to select 3 (control) stores bit 0 as software enable. When that bit is 0, the write also sets the entry mask and clears the pending count.
- R10: Each expiry adds one to the pending count, which saturates at 2^PEND_W − 1 (15 by default).
- R11: irq_req is high exactly when the pending count is nonzero, hw_en is high and the entry is unmasked, and irq_vector gives the entry's vector. An irq_ack while irq_req is high removes one pending expiry. An irq_ack while irq_req is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Hardware enable that gates delivery |
| bus_tick | input | 1 | One-cycle bus clock tick strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 entry, 1 initial count, 2 divide config, 3 control |
| wr_data | input | 32 | Write data |
| irq_ack | input | 1 | Delivery acknowledge |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 8 | Vector carried by the request |
| cur_count | output | CNT_W | Current count |
| pending_count | output | PEND_W | Expiries not yet delivered |
| entry_o | output | 32 | Timer entry readback |
| init_count_o | output | CNT_W | Initial count readback |
| div_cfg_o | output | 4 | Divide configuration readback |
| sw_enabled | output | 1 | Software enable readback |

## Verification
The bench targets the irregular divide decode. It checks that the all-ones code divides by one, that bit 2 is ignored and that the largest codes reach 128. A wrong bit gather would show up as expiries arriving early or late. It restarts a half-elapsed count and confirms that the prescaler phase is discarded. A design that kept the phase would decrement before a full ratio of ticks. It drives the pending count into saturation, where a wrapping counter would fall back to zero. It also checks acknowledges given while hw_en is low or the entry is masked, which a careless design would let retire an expiry. Random divide codes and initial counts are checked against tick-exact expected counts.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int VEC_W = 8;
    localparam int PRE_W = 7;
    localparam int MASK_BIT = 16;
    localparam int PER_BIT = 17;

    typedef enum logic [1:0] {
        SEL_ENTRY = 2'd0,
        SEL_INIT  = 2'd1,
        SEL_DIV   = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             periodic;
        logic             mask;
        logic [VEC_W-1:0] vector;
    } entry_t;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    // Gather bits 3,1,0 and add one; the 3-bit wrap turns 7 into 0 (ratio 1).
    function automatic logic [2:0] ratio_log2(input logic [3:0] cfg);
        logic [2:0] gathered;
        gathered = {cfg[3], cfg[1:0]};
        return gathered + 3'd1;
    endfunction

endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler
    import dct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_tick,
    input  logic       restart,
    input  logic [2:0] log2_ratio,
    output logic       div_tick
);

    pre_state_t        st_d, st_q;
    logic [PRE_W:0]    one_hot;
    logic [PRE_W-1:0]  ratio_m1;
    logic [PRE_W:0]    ratio_m1_w;

    always_comb begin
        one_hot    = {{PRE_W{1'b0}}, 1'b1} << log2_ratio;
        ratio_m1_w = one_hot - {{PRE_W{1'b0}}, 1'b1};
        ratio_m1   = ratio_m1_w[PRE_W-1:0];
        div_tick   = bus_tick && !restart && (st_q.cnt >= ratio_m1);
        st_d       = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (bus_tick) begin
            if (div_tick) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + {{(PRE_W-1){1'b0}}, 1'b1};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             div_tick,
    input  logic             periodic,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cur;
    } cnt_state_t;

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_state_t st_d, st_q;
    logic       running;
    logic       last_step;

    always_comb begin
        running   = (st_q.cur != '0);
        last_step = (st_q.cur == ONE);
        expire    = !load && div_tick && last_step;
        st_d      = st_q;
        if (load) begin
            st_d.cur = load_val;
        end else if (div_tick && running) begin
            if (last_step) begin
                st_d.cur = periodic ? reload_val : '0;
            end else begin
                st_d.cur = st_q.cur - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur = st_q.cur;

endmodule

// File: rtl/dct_pending.sv
module dct_pending #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    input  logic              clr,
    output logic [PEND_W-1:0] count
);

    typedef struct packed {
        logic [PEND_W-1:0] cnt;
    } pend_state_t;

    localparam logic [PEND_W-1:0] FULL = {PEND_W{1'b1}};
    localparam logic [PEND_W-1:0] ONE  = {{(PEND_W-1){1'b0}}, 1'b1};

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc && !dec) begin
            if (st_q.cnt != FULL) begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end else if (dec && !inc) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/div_countdown_timer.sv
module div_countdown_timer
    import dct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              bus_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector,
    output logic [CNT_W-1:0]  cur_count,
    output logic [PEND_W-1:0] pending_count,
    output logic [31:0]       entry_o,
    output logic [CNT_W-1:0]  init_count_o,
    output logic [3:0]        div_cfg_o,
    output logic              sw_enabled
);

    typedef struct packed {
        entry_t           entry;
        logic [CNT_W-1:0] init;
        logic [3:0]       divcfg;
        logic             sw_en;
    } regs_t;

    localparam int ENTRY_PAD = 32 - (PER_BIT + 1);
    localparam int GAP_W     = MASK_BIT - VEC_W;

    regs_t      rg_d, rg_q;
    reg_sel_e   sel;
    logic       wr_entry, wr_init, wr_div, wr_ctrl;
    logic       sw_off_wr;
    logic       div_tick;
    logic       expire;
    logic       deliver;
    logic [2:0] log2_ratio;
    logic       unused_bits;

    assign unused_bits = ^{wr_data[31:PER_BIT+1], wr_data[MASK_BIT-1:VEC_W]};

    always_comb begin
        sel       = reg_sel_e'(wr_sel);
        wr_entry  = wr_en && (sel == SEL_ENTRY);
        wr_init   = wr_en && (sel == SEL_INIT);
        wr_div    = wr_en && (sel == SEL_DIV);
        wr_ctrl   = wr_en && (sel == SEL_CTRL);
        sw_off_wr = wr_ctrl && !wr_data[0];

        rg_d = rg_q;
        if (wr_entry) begin
            rg_d.entry.vector   = wr_data[VEC_W-1:0];
            rg_d.entry.periodic = wr_data[PER_BIT];
            rg_d.entry.mask     = wr_data[MASK_BIT] || !rg_q.sw_en;
        end
        if (wr_init) begin
            rg_d.init = CNT_W'(wr_data);
        end
        if (wr_div) begin
            rg_d.divcfg = wr_data[3:0];
        end
        if (wr_ctrl) begin
            rg_d.sw_en = wr_data[0];
            if (!wr_data[0]) begin
                rg_d.entry.mask = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q.entry.vector   <= '0;
            rg_q.entry.periodic <= 1'b0;
            rg_q.entry.mask     <= 1'b1;
            rg_q.init           <= '0;
            rg_q.divcfg         <= '0;
            rg_q.sw_en          <= 1'b0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign log2_ratio = ratio_log2(rg_q.divcfg);

    dct_prescaler u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_tick   (bus_tick),
        .restart    (wr_init),
        .log2_ratio (log2_ratio),
        .div_tick   (div_tick)
    );

    dct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_init),
        .load_val   (CNT_W'(wr_data)),
        .div_tick   (div_tick),
        .periodic   (rg_q.entry.periodic),
        .reload_val (rg_q.init),
        .cur        (cur_count),
        .expire     (expire)
    );

    assign irq_req    = (pending_count != '0) && hw_en && !rg_q.entry.mask;
    assign irq_vector = rg_q.entry.vector;
    assign deliver    = irq_req && irq_ack;

    dct_pending #(.PEND_W(PEND_W)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (expire),
        .dec   (deliver),
        .clr   (sw_off_wr),
        .count (pending_count)
    );

    assign entry_o      = {{ENTRY_PAD{1'b0}}, rg_q.entry.periodic, rg_q.entry.mask,
                           {GAP_W{1'b0}}, rg_q.entry.vector};
    assign init_count_o = rg_q.init;
    assign div_cfg_o    = rg_q.divcfg;
    assign sw_enabled   = rg_q.sw_en;

endmodule

// File: rtl/div_countdown_timer_chk.sv
module div_countdown_timer_chk #(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_en,
    input logic              bus_tick,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [31:0]       wr_data,
    input logic              irq_ack,
    input logic              irq_req,
    input logic [7:0]        irq_vector,
    input logic [CNT_W-1:0]  cur_count,
    input logic [PEND_W-1:0] pending_count,
    input logic [31:0]       entry_o,
    input logic [CNT_W-1:0]  init_count_o,
    input logic [3:0]        div_cfg_o,
    input logic              sw_enabled
);

    localparam logic [PEND_W-1:0] FULL = {PEND_W{1'b1}};

    logic ctrl_off;
    assign ctrl_off = wr_en && (wr_sel == 2'd3) && !wr_data[0];

    // R7
    always @(posedge clk) begin
        if (rst_n) begin
            a_r7_reserved_zero: assert ((entry_o[31:18] == '0) && (entry_o[15:8] == '0))
                else $error("reserved entry bits set");
        end
    end

    // R11: no request while masked or hardware disabled
    a_r11_no_req_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_o[16] || !hw_en) |-> !irq_req);

    // R11: vector carried matches entry
    a_r11_vector: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector == entry_o[7:0]));

    // R8
    a_r8_mask_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == 2'd0) && !sw_enabled) |=> entry_o[16]);

    // R9
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_off |=> ((pending_count == '0) && entry_o[16] && !sw_enabled));

    // R10
    a_r10_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending_count == FULL) && !irq_ack && !ctrl_off) |=> (pending_count == FULL));

    // R6
    a_r6_stays_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_count == '0) && !wr_en) |=> (cur_count == '0));

    // R4 / R5: count moves by at most one step or reloads
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_count != '0) && !wr_en) |=>
        ((cur_count == $past(cur_count)) || (cur_count == $past(cur_count) - 1'b1)
         || (cur_count == init_count_o)));

    // R4: without a bus tick the count holds
    a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_tick && !wr_en) |=> $stable(cur_count));

endmodule

bind div_countdown_timer div_countdown_timer_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hw_en         (hw_en),
    .bus_tick      (bus_tick),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .irq_ack       (irq_ack),
    .irq_req       (irq_req),
    .irq_vector    (irq_vector),
    .cur_count     (cur_count),
    .pending_count (pending_count),
    .entry_o       (entry_o),
    .init_count_o  (init_count_o),
    .div_cfg_o     (div_cfg_o),
    .sw_enabled    (sw_enabled)
);

// File: tb/div_countdown_timer_bench.sv
module div_countdown_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_en = 1'b0;
    logic        bus_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [7:0]  irq_vector;
    logic [31:0] cur_count;
    logic [3:0]  pending_count;
    logic [31:0] entry_o;
    logic [31:0] init_count_o;
    logic [3:0]  div_cfg_o;
    logic        sw_enabled;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_pend = 0;

    always #10ns clk = ~clk;

    div_countdown_timer u_div_countdown_timer (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .bus_tick(bus_tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vector(irq_vector), .cur_count(cur_count),
        .pending_count(pending_count), .entry_o(entry_o),
        .init_count_o(init_count_o), .div_cfg_o(div_cfg_o), .sw_enabled(sw_enabled)
    );

    function automatic int ratio_of(input logic [3:0] cfg);
        int code;
        code = ((cfg[3] ? 4 : 0) + (cfg[1] ? 2 : 0) + (cfg[0] ? 1 : 0) + 1) % 8;
        return 1 << code;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            bus_tick = 1'b1;
            repeat (n) @(negedge clk);
            bus_tick = 1'b0;
        end
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        #(20ns * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 entry", entry_o, 32'h0001_0000);
        chk("R1 init", init_count_o, 0);
        chk("R1 cfg", {28'd0, div_cfg_o}, 0);
        chk("R1 cur", cur_count, 0);
        chk("R1 pend", {28'd0, pending_count}, 0);
        chk("R1 req", {31'd0, irq_req}, 0);
        chk("R1 swen", {31'd0, sw_enabled}, 0);

        // R8 mask forced while software disabled
        wr(2'd0, 32'h0000_0042);
        chk("R8 forced mask", entry_o, 32'h0001_0042);

        // R7 field layout
        wr(2'd3, 32'h1);
        chk("R9 swen set", {31'd0, sw_enabled}, 1);
        wr(2'd0, 32'hFFFF_FFFF);
        chk("R7 reserved zero", entry_o, 32'h0003_00FF);
        wr(2'd0, 32'h0000_0042);
        chk("R7 unmasked oneshot", entry_o, 32'h0000_0042);

        // R2/R4 ratio 2, one-shot
        wr(2'd2, 32'h0);
        wr(2'd1, 32'd5);
        chk("R3 load", cur_count, 5);
        ticks(1);
        chk("R2 cfg0 not div1", cur_count, 5);
        ticks(8);
        chk("R4 count", cur_count, 1);
        chk("R4 no early expiry", {28'd0, pending_count}, 0);
        ticks(1);
        exp_pend = 1;
        chk("R4 reach zero", cur_count, 0);
        chk("R10 expiry", {28'd0, pending_count}, exp_pend);
        ticks(6);
        chk("R4 oneshot stops", cur_count, 0);
        chk("R4 single expiry", {28'd0, pending_count}, exp_pend);

        // R2 code 0xB divides by one
        wr(2'd2, 32'hB);
        wr(2'd1, 32'd4);
        ticks(3);
        chk("R2 div1", cur_count, 1);
        ticks(1);
        exp_pend = 2;
        chk("R2 div1 expiry", {28'd0, pending_count}, exp_pend);

        // R2 bit 2 ignored
        wr(2'd2, 32'h4);
        wr(2'd1, 32'd3);
        ticks(1);
        chk("R2 bit2 ignored a", cur_count, 3);
        ticks(1);
        chk("R2 bit2 ignored b", cur_count, 2);

        // R3 restart discards prescaler phase (ratio 16)
        wr(2'd2, 32'h3);
        wr(2'd1, 32'd10);
        ticks(20);
        chk("R2 div16", cur_count, 9);
        wr(2'd1, 32'd7);
        chk("R3 reload value", cur_count, 7);
        ticks(15);
        chk("R3 phase reset", cur_count, 7);
        ticks(1);
        chk("R3 first step", cur_count, 6);

        // R6 zero stops
        wr(2'd1, 32'd0);
        chk("R6 cur zero", cur_count, 0);
        ticks(40);
        chk("R6 still zero", cur_count, 0);
        chk("R6 no expiry", {28'd0, pending_count}, exp_pend);

        // R5 periodic
        wr(2'd0, 32'h0002_0042);
        wr(2'd2, 32'h0);
        wr(2'd1, 32'd3);
        ticks(6);
        exp_pend = 3;
        chk("R5 reload", cur_count, 3);
        chk("R5 expiry", {28'd0, pending_count}, exp_pend);
        ticks(5);
        chk("R5 mid", cur_count, 1);
        ticks(1);
        exp_pend = 4;
        chk("R5 reload again", cur_count, 3);
        chk("R5 second expiry", {28'd0, pending_count}, exp_pend);

        // R10 saturation
        wr(2'd2, 32'hB);
        wr(2'd1, 32'd1);
        ticks(20);
        chk("R10 saturate", {28'd0, pending_count}, 15);
        wr(2'd1, 32'd0);
        chk("R10 held", {28'd0, pending_count}, 15);

        // R11 delivery
        #1ns;
        chk("R11 no req hw off", {31'd0, irq_req}, 0);
        @(negedge clk);
        hw_en = 1'b1;
        #1ns;
        chk("R11 req", {31'd0, irq_req}, 1);
        chk("R11 vector", {24'd0, irq_vector}, 32'h42);
        @(negedge clk);
        ack_pulse();
        chk("R11 ack retires", {28'd0, pending_count}, 14);
        hw_en = 1'b0;
        ack_pulse();
        chk("R11 ack ignored hw off", {28'd0, pending_count}, 14);
        hw_en = 1'b1;
        wr(2'd0, 32'h0003_0042);
        chk("R11 masked no req", {31'd0, irq_req}, 0);
        ack_pulse();
        chk("R11 ack ignored masked", {28'd0, pending_count}, 14);
        wr(2'd0, 32'h0002_0042);
        chk("R11 unmasked req", {31'd0, irq_req}, 1);

        // R9 disable clears
        wr(2'd3, 32'h0);
        chk("R9 pend cleared", {28'd0, pending_count}, 0);
        chk("R9 mask set", entry_o, 32'h0003_0042);
        chk("R9 swen clear", {31'd0, sw_enabled}, 0);
        hw_en = 1'b0;

        // Random R2/R4 sweep
        for (int it = 0; it < 12; it++) begin
            logic [3:0] cfg;
            int n, r, k;
            cfg = 4'($urandom);
            n   = 1 + int'($urandom % 12);
            r   = ratio_of(cfg);
            k   = int'($urandom % (n * r));
            wr(2'd3, 32'h0);
            wr(2'd3, 32'h1);
            wr(2'd0, 32'h0000_0042);
            wr(2'd2, {28'd0, cfg});
            wr(2'd1, n);
            ticks(k);
            chk("R2 random mid", cur_count, n - k / r);
            ticks(n * r - 1 - k);
            chk("R4 random last", cur_count, 1);
            chk("R4 random no expiry", {28'd0, pending_count}, 0);
            ticks(1);
            chk("R4 random zero", cur_count, 0);
            chk("R10 random expiry", {28'd0, pending_count}, 1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule